// File: doc/BRIEF.md
# Handshaked Register File

This block is the general-purpose register storage of a processor datapath in which stages talk to each other through four-phase request/acknowledge handshakes and not through fixed clock slots. It holds thirty-two 32-bit general registers and two further 32-bit registers, HI and LO, that receive the results of multiply and divide operations.

A decode stage reads two operands with a four-phase transaction on the read port. It presents two indices with a request, and the block acknowledges once it has latched them. The two values then go back on a second, separate request/acknowledge pair. A writeback stage updates one register at a time through its own four-phase write port. A write carries a destination code, a data word and a per-byte enable mask. Each side drops back to idle by itself (self-reset) once its handshakes have returned to zero.

A write that is pending when a read arrives is always completed first, so the read sees the new contents. The destination and index code space covers codes 0 to 31 for the general registers, 32 for HI and 33 for LO. Register 0 is hard-wired to zero.

Top module: `hs_regfile`

## Requirements
- R1: After a synchronous active-low reset, rd_ack, val_req and wr_ack are low, and every register, including HI and LO, reads as zero.
- R2: A write request is taken while the write side is idle. wr_ack rises only after the data has been stored, stays high for as long as wr_req is high, and falls on the first clock edge at which wr_req is seen low.
- R3: Write-enable bit i of wr_be (i = 0..3) controls data bits 8i+7 down to 8i. Only the bytes whose enable bit is 1 change, and the other bytes keep their old value.
- R4: Register 0 always reads as zero. A write to destination code 0 has no effect.
- R5: The destination and index codes are 0 to 31 for the general registers, 32 for HI and 33 for LO. A write to codes 34 to 63 changes nothing, and a read of codes 34 to 63 returns zero.
- R6: rd_ack rises when a read is accepted, stays high while rd_req is high, and falls on the first clock edge at which rd_req is seen low.
- R7: val_req rises together with rd_ack. val_a holds the value of the register at index rd_idx_a, and val_b the value at rd_idx_b, both taken at acceptance. While val_req is high and val_ack is low, val_req, val_a and val_b do not change. val_req falls on the first edge at which val_ack is seen high.
- R8: A new read is not accepted until rd_ack and val_req have both returned low and val_ack has been seen low.
- R9: When a write and a read are requested together, the write is carried out first and the read returns the newly written value.
- R10: No read is accepted while a write request is pending or a write is in progress, including its acknowledge phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request, four-phase |
| rd_idx_a | input | 6 | First read index code |
| rd_idx_b | input | 6 | Second read index code |
| rd_ack | output | 1 | Read acknowledge (indices latched) |
| val_req | output | 1 | Result request, values valid while high |
| val_a | output | 32 | Value selected by rd_idx_a |
| val_b | output | 32 | Value selected by rd_idx_b |
| val_ack | input | 1 | Result acknowledge from the consumer |
| wr_req | input | 1 | Write request, four-phase |
| wr_dst | input | 6 | Destination code |
| wr_data | input | 32 | Write data word |
| wr_be | input | 4 | Per-byte write enables |
| wr_ack | output | 1 | Write acknowledge (data stored) |

## Verification
The hardest situation to reach is a read and a write that contend for the block. Both must be raised in the same cycle, and the read must then be held off through the whole write, acknowledge phase included. The priority scenario raises wr_req and rd_req on the same falling edge, with the read aimed at the register being written. It watches rd_ack stay low on every cycle of the write, then completes the read and compares the returned word with the new value. A second contention case keeps val_ack high while a fresh rd_req is raised, which shows that the read side does not self-reset until the consumer has released its acknowledge.

// File: rtl/hsrf_pkg.sv
// Package of shared constants for the handshaked register file.
// Assumes the general registers are followed in the code space by HI and LO.
package hsrf_pkg;
    localparam int XLEN_DEF = 32;
    localparam int NGPR_DEF = 32;

    // Write-side sequencing states
    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_COMMIT = 2'd1,
        W_ACK    = 2'd2
    } wr_state_t;
endpackage

// File: rtl/hsrf_wr_latch.sv
// Write latch: takes a four-phase write request, holds destination, data
// and byte mask, issues a one-cycle commit strobe to storage, then
// acknowledges. It self-resets once the request has been withdrawn.
// Assumes the requester keeps its fields stable while wr_req is high.
module hsrf_wr_latch
    import hsrf_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int IDXW = 6,
    localparam int BEW = XLEN / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [IDXW-1:0] wr_dst,
    input  logic [XLEN-1:0] wr_data,
    input  logic [BEW-1:0]  wr_be,
    output logic            wr_ack,
    output logic            busy,
    output logic            commit,
    output logic [IDXW-1:0] cmt_dst,
    output logic [XLEN-1:0] cmt_data,
    output logic [BEW-1:0]  cmt_be
);
    wr_state_t state_q;

    // Sequence the write: latch, commit, acknowledge, self-reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= W_IDLE;
            cmt_dst  <= '0;
            cmt_data <= '0;
            cmt_be   <= '0;
        end else begin
            case (state_q)
                W_IDLE: if (wr_req) begin
                    state_q  <= W_COMMIT;
                    cmt_dst  <= wr_dst;
                    cmt_data <= wr_data;
                    cmt_be   <= wr_be;
                end
                W_COMMIT: state_q <= W_ACK;
                W_ACK: if (!wr_req) begin
                    state_q  <= W_IDLE;
                    cmt_dst  <= '0;
                    cmt_data <= '0;
                    cmt_be   <= '0;
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    // Decode the state into handshake and control outputs
    always_comb begin
        wr_ack = (state_q == W_ACK);
        commit = (state_q == W_COMMIT);
        busy   = (state_q != W_IDLE);
    end

    // R2
    wr_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && wr_req) |=> wr_ack);

    // R2
    wr_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !wr_req) |=> !wr_ack);
endmodule

// File: rtl/hsrf_store.sv
// Storage for the general registers plus HI and LO, all in one code space.
// Slot 0 is tied to zero. Writes merge bytes under the enable mask. The two
// read ports are combinational, and codes beyond the last slot read zero.
// Assumes at most one write per cycle, delivered as a one-cycle strobe.
module hsrf_store
    import hsrf_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int NGPR = NGPR_DEF,
    parameter int IDXW = 6,
    localparam int BEW   = XLEN / 8,
    localparam int NSLOT = NGPR + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] w_dst,
    input  logic [XLEN-1:0] w_data,
    input  logic [BEW-1:0]  w_be,
    input  logic [IDXW-1:0] ra_idx,
    input  logic [IDXW-1:0] rb_idx,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val
);
    logic [XLEN-1:0] slot_w [NSLOT];

    // Merge new bytes into an old word under the enable mask
    function automatic logic [XLEN-1:0] merge_bytes(
        input logic [XLEN-1:0] old_w,
        input logic [XLEN-1:0] new_w,
        input logic [BEW-1:0]  be
    );
        logic [XLEN-1:0] r;
        r = old_w;
        for (int b = 0; b < BEW; b++) begin
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction

    assign slot_w[0] = '0;

    for (genvar g = 1; g < NSLOT; g++) begin : g_slot
        logic [XLEN-1:0] q;
        // Hold one register and apply masked writes addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (we && (w_dst == IDXW'(g))) q <= merge_bytes(q, w_data, w_be);
        end
        assign slot_w[g] = q;
    end

    // Select the two read values, with zero for unused codes
    always_comb begin
        ra_val = '0;
        rb_val = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (ra_idx == IDXW'(s)) ra_val = slot_w[s];
            if (rb_idx == IDXW'(s)) rb_val = slot_w[s];
        end
    end

    // R4
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == '0) |-> (ra_val == '0));
endmodule

// File: rtl/hsrf_rd_latch.sv
// Read latch and result sender: accepts a four-phase read of two indices,
// captures both values at acceptance, returns them on a separate
// request/acknowledge pair, and self-resets once both handshakes are at zero.
// Assumes `allow` is low whenever a write is pending or running.
module hsrf_rd_latch
    import hsrf_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            allow,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    input  logic            val_ack,
    output logic            rd_ack,
    output logic            val_req,
    output logic [XLEN-1:0] val_a,
    output logic [XLEN-1:0] val_b
);
    logic busy_q;

    // Run both read handshakes and the self-reset back to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rd_ack  <= 1'b0;
            val_req <= 1'b0;
            val_a   <= '0;
            val_b   <= '0;
        end else if (!busy_q) begin
            if (rd_req && allow) begin
                busy_q  <= 1'b1;
                rd_ack  <= 1'b1;
                val_req <= 1'b1;
                val_a   <= ra_val;
                val_b   <= rb_val;
            end
        end else begin
            if (rd_ack && !rd_req) rd_ack <= 1'b0;
            if (val_req && val_ack) val_req <= 1'b0;
            if (!rd_ack && !val_req && !val_ack) busy_q <= 1'b0;
        end
    end

    // R6
    rd_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_req) |=> rd_ack);

    // R7
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_req && !val_ack) |=> (val_req && $stable(val_a) && $stable(val_b)));

    // R8
    rd_idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ack) |-> !$past(val_req));
endmodule

// File: rtl/hs_regfile.sv
// Top of the handshaked register file: a write latch and a read latch share
// one storage block. Write-over-read priority comes from holding the read
// side off while a write is requested or in progress.
// Assumes one requester per port, each following the four-phase protocol.
module hs_regfile
    import hsrf_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int NGPR = NGPR_DEF,
    localparam int IDXW = $clog2(NGPR + 2),
    localparam int BEW  = XLEN / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic [IDXW-1:0] rd_idx_a,
    input  logic [IDXW-1:0] rd_idx_b,
    output logic            rd_ack,
    output logic            val_req,
    output logic [XLEN-1:0] val_a,
    output logic [XLEN-1:0] val_b,
    input  logic            val_ack,
    input  logic            wr_req,
    input  logic [IDXW-1:0] wr_dst,
    input  logic [XLEN-1:0] wr_data,
    input  logic [BEW-1:0]  wr_be,
    output logic            wr_ack
);
    logic            wr_busy;
    logic            wr_commit;
    logic [IDXW-1:0] c_dst;
    logic [XLEN-1:0] c_data;
    logic [BEW-1:0]  c_be;
    logic [XLEN-1:0] ra_val;
    logic [XLEN-1:0] rb_val;
    logic            rd_allow;

    // Reads wait for any pending or running write
    assign rd_allow = !wr_busy && !wr_req;

    hsrf_wr_latch #(.XLEN(XLEN), .IDXW(IDXW)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_dst(wr_dst),
        .wr_data(wr_data), .wr_be(wr_be), .wr_ack(wr_ack), .busy(wr_busy),
        .commit(wr_commit), .cmt_dst(c_dst), .cmt_data(c_data), .cmt_be(c_be)
    );

    hsrf_store #(.XLEN(XLEN), .NGPR(NGPR), .IDXW(IDXW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_commit), .w_dst(c_dst),
        .w_data(c_data), .w_be(c_be), .ra_idx(rd_idx_a), .rb_idx(rd_idx_b),
        .ra_val(ra_val), .rb_val(rb_val)
    );

    hsrf_rd_latch #(.XLEN(XLEN)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .allow(rd_allow),
        .ra_val(ra_val), .rb_val(rb_val), .val_ack(val_ack),
        .rd_ack(rd_ack), .val_req(val_req), .val_a(val_a), .val_b(val_b)
    );

    // R10
    no_read_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ack) |-> (!wr_ack && !wr_busy));
endmodule

// File: tb/hs_regfile_bench.sv
// Directed bench for hs_regfile: one task per scenario, each checking its
// own results against a reference model kept in the bench.
module hs_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [5:0]  rd_idx_a = '0;
    logic [5:0]  rd_idx_b = '0;
    logic        rd_ack;
    logic        val_req;
    logic [31:0] val_a;
    logic [31:0] val_b;
    logic        val_ack = 1'b0;
    logic        wr_req = 1'b0;
    logic [5:0]  wr_dst = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_ack;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [64];

    always #2 clk = ~clk;

    hs_regfile u_hs_regfile (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx_a(rd_idx_a),
        .rd_idx_b(rd_idx_b), .rd_ack(rd_ack), .val_req(val_req),
        .val_a(val_a), .val_b(val_b), .val_ack(val_ack), .wr_req(wr_req),
        .wr_dst(wr_dst), .wr_data(wr_data), .wr_be(wr_be), .wr_ack(wr_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference write: slots 1..33 only, byte-merged
    task automatic mdl_write(input logic [5:0] d, input logic [31:0] v, input logic [3:0] be);
        if (d != 0 && d < 34) begin
            for (int b = 0; b < 4; b++) if (be[b]) mdl[d][8*b +: 8] = v[8*b +: 8];
        end
    endtask

    task automatic do_write(input logic [5:0] d, input logic [31:0] v,
                            input logic [3:0] be, input int hold);
        @(negedge clk);
        wr_dst = d; wr_data = v; wr_be = be; wr_req = 1'b1;
        for (int i = 0; i < 20 && !wr_ack; i++) @(negedge clk);
        chk(wr_ack, "R2 ack rise", 32'(wr_ack), 1);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(wr_ack, "R2 ack held", 32'(wr_ack), 1);
        end
        wr_req = 1'b0;
        @(negedge clk);
        chk(!wr_ack, "R2 ack fall", 32'(wr_ack), 0);
        mdl_write(d, v, be);
    endtask

    task automatic do_read(input logic [5:0] a, input logic [5:0] b, input string req);
        @(negedge clk);
        rd_idx_a = a; rd_idx_b = b; rd_req = 1'b1;
        for (int i = 0; i < 20 && !rd_ack; i++) @(negedge clk);
        chk(rd_ack && val_req, "R6 R7 accept", 32'({rd_ack, val_req}), 3);
        rd_req = 1'b0;
        chk(val_a == mdl[a], req, val_a, mdl[a]);
        chk(val_b == mdl[b], req, val_b, mdl[b]);
        val_ack = 1'b1;
        @(negedge clk);
        chk(!val_req && !rd_ack, "R6 R7 release", 32'({rd_ack, val_req}), 0);
        val_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!rd_ack && !val_req && !wr_ack, "R1 outputs", 32'({rd_ack, val_req, wr_ack}), 0);
        do_read(6'd1, 6'd31, "R1 gpr zero");
        do_read(6'd32, 6'd33, "R1 hilo zero");
    endtask

    task automatic t_basic;
        do_write(6'd5, 32'hDEADBEEF, 4'hF, 3);
        do_write(6'd31, 32'h0BADF00D, 4'hF, 0);
        do_read(6'd5, 6'd31, "R2 readback");
    endtask

    task automatic t_bytemask;
        do_write(6'd7, 32'hFFFFFFFF, 4'hF, 0);
        do_write(6'd7, 32'h11223344, 4'b0101, 0);
        chk(mdl[7] == 32'hFF22FF44, "R3 model", mdl[7], 32'hFF22FF44);
        do_read(6'd7, 6'd7, "R3 mask 0101");
        do_write(6'd7, 32'hAABBCCDD, 4'b1000, 0);
        do_read(6'd7, 6'd5, "R3 mask 1000");
    endtask

    task automatic t_zero;
        do_write(6'd0, 32'h12345678, 4'hF, 0);
        do_read(6'd0, 6'd5, "R4 r0 zero");
    endtask

    task automatic t_hilo;
        do_write(6'd32, 32'h0000_1111, 4'hF, 0);
        do_write(6'd33, 32'h2222_0000, 4'hF, 0);
        do_write(6'd40, 32'h5555_5555, 4'hF, 0);
        do_read(6'd32, 6'd33, "R5 hi lo");
        do_read(6'd40, 6'd63, "R5 unused code reads zero");
        do_read(6'd5, 6'd7, "R5 unused write no effect");
    endtask

    task automatic t_read_hs;
        logic [31:0] a0;
        @(negedge clk);
        rd_idx_a = 6'd5; rd_idx_b = 6'd32; rd_req = 1'b1;
        for (int i = 0; i < 20 && !rd_ack; i++) @(negedge clk);
        a0 = val_a;
        chk(a0 == mdl[5], "R7 value", a0, mdl[5]);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(rd_ack, "R6 ack held", 32'(rd_ack), 1);
            chk(val_req && val_a == a0, "R7 stable", val_a, a0);
        end
        rd_req = 1'b0;
        @(negedge clk);
        chk(!rd_ack && val_req, "R6 R7 ack fall only", 32'({rd_ack, val_req}), 1);
        val_ack = 1'b1;
        @(negedge clk);
        chk(!val_req, "R7 val_req fall", 32'(val_req), 0);
        rd_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!rd_ack, "R8 no accept while val_ack high", 32'(rd_ack), 0);
        end
        val_ack = 1'b0;
        for (int i = 0; i < 20 && !rd_ack; i++) @(negedge clk);
        chk(rd_ack && val_b == mdl[32], "R8 accept after release", val_b, mdl[32]);
        rd_req = 1'b0;
        val_ack = 1'b1;
        @(negedge clk);
        val_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_priority;
        bit held = 1'b1;
        @(negedge clk);
        wr_dst = 6'd9; wr_data = 32'hC0FFEE09; wr_be = 4'hF; wr_req = 1'b1;
        rd_idx_a = 6'd9; rd_idx_b = 6'd0; rd_req = 1'b1;
        for (int i = 0; i < 20 && !wr_ack; i++) begin
            @(negedge clk);
            if (rd_ack) held = 1'b0;
        end
        mdl_write(6'd9, 32'hC0FFEE09, 4'hF);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (rd_ack) held = 1'b0;
        end
        chk(held, "R10 read held during write", 32'(held), 1);
        wr_req = 1'b0;
        for (int i = 0; i < 20 && !rd_ack; i++) @(negedge clk);
        rd_req = 1'b0;
        chk(val_req && val_a == 32'hC0FFEE09, "R9 read sees write", val_a, 32'hC0FFEE09);
        val_ack = 1'b1;
        @(negedge clk);
        val_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 64; k++) mdl[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bytemask();
        t_zero();
        t_hilo();
        t_read_hs();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule